// File: doc/BRIEF.md
# Synchronous Burst SRAM

This block is a synthesizable behavioural model of a single-port synchronous SRAM organised as words of several byte lanes (four lanes of nine bits by default). Every control input is taken on the rising clock edge, and only while the active-low clock enable is low. When the clock enable is high the whole cycle stretches: nothing is sampled and all internal state holds. Reads and writes share one pipeline. A read returns data two enabled edges after its address edge. A write takes its data two enabled edges after its address edge. Because both directions use the same latency, reads and writes can follow each other with no idle cycle between them.

A load cycle (advance/load low) takes a new address, but only when all three chip enables select the device. Otherwise the load cycle is a deselect. An advance cycle (advance/load high) keeps the burst's direction and upper address bits. It steps the two low address bits in linear order and wraps inside the aligned group of four words. The bidirectional data bus is split into data-in, data-out and a drive-enable. The drive-enable follows the asynchronous active-low output enable, but only while the pipeline is presenting read data.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, and until a read has completed, the drive-enable `dOe` is low.
- R2: A read whose address is taken on enabled edge k drives that word on `dOut` after enabled edge k+2, and `dOe` is then high while `oeN` is low.
- R3: A write whose address is taken on enabled edge k stores the `dIn` value present at enabled edge k+2. Lane g (bits 9g+8..9g by default) is updated only when `bwN[g]` is low on the address edge.
- R4: A load cycle selects the device only when `ce1N` is low, `ce2` is high and `ce3N` is low. Any other combination is a deselect: it performs no write and leaves `dOe` low for the matching data slot.
- R5: An advance cycle of an active burst uses the previous address with its two low bits incremented modulo 4. The upper bits are unchanged and the `addr` input is ignored.
- R6: While `cenN` is high, clock edges are ignored. `dOut` and `dOe` hold, and no command is taken, so a write offered then changes no memory.
- R7: `oeN` acts without a clock edge. While read data is presented, `dOe` follows `~oeN` at once.
- R8: During the data slot of a write, `dOe` is low even if `oeN` is low.
- R9: An advance cycle while no burst is active (after a deselect) is a deselect: no write, and `dOe` stays low for its data slot.
- R10: A write followed on the next edge by a read of the same address returns the newly written word, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of the control and output pipeline |
| cenN | input | 1 | Active-low clock enable; high freezes the cycle |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| advLd | input | 1 | High: advance the burst; low: load a new address |
| weN | input | 1 | Active-low write enable, taken on load cycles |
| bwN | input | LANES | Active-low per-lane write strobes, taken with the address |
| addr | input | ADDR_W | Word address |
| oeN | input | 1 | Asynchronous active-low output enable |
| dIn | input | LANES*LANE_W | Write data |
| dOut | output | LANES*LANE_W | Read data |
| dOe | output | 1 | Drive-enable for the data bus |

## Verification
The bench builds the block with ADDR_W = 6 and keeps the default four lanes of nine bits. With this depth, the words used for bursts, masked writes and stalled cycles all fit in a small address range that is easy to track. A burst started at word 6 has to wrap back to word 4 inside its aligned group, which exercises the modulo-4 step. Keeping the default lane layout means the lane-masked merges are checked on the same bit positions that the full-size model uses.

// File: rtl/sram_pkg.sv
package sram_pkg;

  // Strobes handed from the control pipeline to the storage datapath.
  typedef struct packed {
    logic cke;     // edge is recognised (clock enable asserted)
    logic wrData;  // current stage-2 slot is a write data slot
    logic rdData;  // current stage-2 slot is a read data slot
  } dpStrobe_t;

  // Kind of command taken on an edge.
  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_LOAD = 2'd1,
    CYC_ADV  = 2'd2
  } cycKind_t;

endpackage

// File: rtl/sram_burst_addr.sv
module sram_burst_addr #(
  parameter int ADDR_W = 9,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] loadAddr,
  output logic [ADDR_W-1:0] effAddr
);

  localparam int UPPER_W = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] lastAddr;
  logic [CNT_W-1:0]  stepLow;
  logic [UPPER_W-1:0] upperHold;

  assign upperHold = lastAddr[ADDR_W-1:CNT_W];
  assign stepLow   = lastAddr[CNT_W-1:0] + CNT_W'(1);
  assign effAddr   = load ? loadAddr : {upperHold, stepLow};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastAddr <= '0;
    end else if (cke && (load || adv)) begin
      lastAddr <= effAddr;
    end
  end

  // R5: an advance steps the low bits modulo 4 and keeps the upper bits
  assert_burst_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cke && adv && !load) |=>
      ((lastAddr[CNT_W-1:0] == CNT_W'($past(lastAddr[CNT_W-1:0]) + CNT_W'(1))) &&
       $stable(upperHold)));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cenN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              advLd,
  input  logic              weN,
  input  logic [LANES-1:0]  bwN,
  input  logic [ADDR_W-1:0] effAddr,
  output logic              cntLoad,
  output logic              cntAdv,
  output logic              cke,
  output dpStrobe_t         strb,
  output logic [ADDR_W-1:0] dpAddr,
  output logic [LANES-1:0]  dpMask
);

  cycKind_t kind;
  logic sel, opValid, opWrite;
  logic burstActive, burstWrite;

  logic              s1Valid, s1Write;
  logic [ADDR_W-1:0] s1Addr;
  logic [LANES-1:0]  s1Mask;
  logic              s2Valid, s2Write;
  logic [ADDR_W-1:0] s2Addr;
  logic [LANES-1:0]  s2Mask;

  always_comb begin
    cke = ~cenN;
    sel = ~ce1N & ce2 & ~ce3N;
    if (!advLd) begin
      kind = sel ? CYC_LOAD : CYC_IDLE;
    end else begin
      kind = burstActive ? CYC_ADV : CYC_IDLE;
    end
    opValid = (kind != CYC_IDLE);
    opWrite = (kind == CYC_LOAD) ? ~weN : burstWrite;
  end

  assign cntLoad = (kind == CYC_LOAD);
  assign cntAdv  = (kind == CYC_ADV);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstActive <= 1'b0;
      burstWrite  <= 1'b0;
      s1Valid     <= 1'b0;
      s1Write     <= 1'b0;
      s1Addr      <= '0;
      s1Mask      <= '0;
      s2Valid     <= 1'b0;
      s2Write     <= 1'b0;
      s2Addr      <= '0;
      s2Mask      <= '0;
    end else if (cke) begin
      burstActive <= opValid;
      burstWrite  <= opWrite;
      s1Valid     <= opValid;
      s1Write     <= opWrite;
      s1Addr      <= effAddr;
      s1Mask      <= ~bwN;
      s2Valid     <= s1Valid;
      s2Write     <= s1Write;
      s2Addr      <= s1Addr;
      s2Mask      <= s1Mask;
    end
  end

  always_comb begin
    strb.cke    = cke;
    strb.wrData = s2Valid & s2Write;
    strb.rdData = s2Valid & ~s2Write;
  end

  assign dpAddr = s2Addr;
  assign dpMask = s2Mask;

  // R4: a load cycle with any chip enable inactive issues nothing
  assert_deselect_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cke && !advLd && !sel) |=> !s1Valid);

  // R9: an advance with no burst active issues nothing
  assert_adv_noop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cke && advLd && !burstActive) |=> !s1Valid);

  // R6: a masked edge leaves the command pipeline untouched
  assert_pipe_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !cke |=> ($stable(s1Valid) && $stable(s2Valid) && $stable(s1Addr)));

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strb,
  input  logic [ADDR_W-1:0]       dpAddr,
  input  logic [LANES-1:0]        dpMask,
  input  logic [LANES*LANE_W-1:0] dIn,
  input  logic                    oeN,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    dOe
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] rdWord;
  logic [DATA_W-1:0] dReg;
  logic              outValid;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (strb.cke && strb.wrData && dpMask[g]) begin
        bank[dpAddr] <= dIn[g*LANE_W +: LANE_W];
      end
    end

    assign rdWord[g*LANE_W +: LANE_W] = bank[dpAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dReg     <= '0;
      outValid <= 1'b0;
    end else if (strb.cke) begin
      outValid <= strb.rdData;
      if (strb.rdData) begin
        dReg <= rdWord;
      end
    end
  end

  assign dOut = dReg;
  assign dOe  = outValid & ~oeN;

  // R8: the slot after a write data edge never drives the bus
  assert_write_slot_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cke && strb.wrData) |=> !outValid);

  // R6: a masked edge holds the presented data and its valid flag
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cke |=> ($stable(dReg) && $stable(outValid)));

  // R2: a read data slot always presents data on the next enabled edge
  assert_read_slot_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cke && strb.rdData) |=> outValid);

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cenN,
  input  logic                    ce1N,
  input  logic                    ce2,
  input  logic                    ce3N,
  input  logic                    advLd,
  input  logic                    weN,
  input  logic [LANES-1:0]        bwN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    oeN,
  input  logic [LANES*LANE_W-1:0] dIn,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    dOe
);

  localparam int CNT_W = 2;

  logic              cntLoad, cntAdv, cke;
  logic [ADDR_W-1:0] effAddr, dpAddr;
  logic [LANES-1:0]  dpMask;
  dpStrobe_t         strb;

  sram_burst_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_burst (
    .clk(clk), .rstN(rstN), .cke(cke), .load(cntLoad), .adv(cntAdv),
    .loadAddr(addr), .effAddr(effAddr)
  );

  sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) i_ctrl (
    .clk(clk), .rstN(rstN), .cenN(cenN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .advLd(advLd), .weN(weN), .bwN(bwN), .effAddr(effAddr),
    .cntLoad(cntLoad), .cntAdv(cntAdv), .cke(cke),
    .strb(strb), .dpAddr(dpAddr), .dpMask(dpMask)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dpAddr(dpAddr), .dpMask(dpMask),
    .dIn(dIn), .oeN(oeN), .dOut(dOut), .dOe(dOe)
  );

endmodule

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;

  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;

  logic clk = 1'b0;
  logic rstN, cenN, ce1N, ce2, ce3N, advLd, weN, oeN;
  logic [LANES-1:0]  bwN;
  logic [ADDR_W-1:0] addr;
  logic [DW-1:0]     dIn, dOut;
  logic              dOe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sync_burst_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_sync_burst_sram (
    .clk(clk), .rstN(rstN), .cenN(cenN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .advLd(advLd), .weN(weN), .bwN(bwN), .addr(addr), .oeN(oeN),
    .dIn(dIn), .dOut(dOut), .dOe(dOe)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkBit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(logic [DW-1:0] oldW, logic [DW-1:0] newW,
                                          logic [LANES-1:0] strobesN);
    logic [DW-1:0] r = oldW;
    for (int g = 0; g < LANES; g++) begin
      if (!strobesN[g]) r[g*LANE_W +: LANE_W] = newW[g*LANE_W +: LANE_W];
    end
    return r;
  endfunction

  task automatic setIdle();
    cenN = 1'b0; ce1N = 1'b1; ce2 = 1'b1; ce3N = 1'b0;
    advLd = 1'b0; weN = 1'b1; bwN = '1;
  endtask

  task automatic setCmd(logic [ADDR_W-1:0] a, logic wr, logic [LANES-1:0] bw);
    cenN = 1'b0; ce1N = 1'b0; ce2 = 1'b1; ce3N = 1'b0;
    advLd = 1'b0; weN = ~wr; bwN = bw; addr = a;
  endtask

  task automatic doWrite(logic [ADDR_W-1:0] a, logic [DW-1:0] d, logic [LANES-1:0] bw);
    setCmd(a, 1'b1, bw);
    tick();
    setIdle();
    tick();
    dIn = d;
    tick();
  endtask

  task automatic doRead(logic [ADDR_W-1:0] a, logic [DW-1:0] exp, string req);
    setCmd(a, 1'b0, '1);
    tick();
    setIdle();
    tick();
    tick();
    chk(req, dOut, exp);
    chkBit(req, dOe, 1'b1);
  endtask

  logic [DW-1:0] m5, m9;

  task automatic t_reset();
    chkBit("R1 dOe low after reset", dOe, 1'b0);
    tick();
    chkBit("R1 dOe low while idle", dOe, 1'b0);
  endtask

  task automatic t_basic();
    m5 = 36'h1_2345_6789;
    doWrite(5, m5, 4'b0000);
    doRead(5, m5, "R2 read latency");
    doWrite(6, 36'hF_0F0F_0F0F, 4'b0000);
    doRead(6, 36'hF_0F0F_0F0F, "R3 full write");
  endtask

  task automatic t_bytes();
    logic [DW-1:0] nw = 36'hA_BCDE_F012;
    m5 = merge(m5, nw, 4'b1010);
    doWrite(5, nw, 4'b1010);
    doRead(5, m5, "R3 lanes 0 and 2 only");
    m5 = merge(m5, 36'h0_0000_0000, 4'b0111);
    doWrite(5, 36'h0_0000_0000, 4'b0111);
    doRead(5, m5, "R3 lane 3 only");
  endtask

  task automatic t_select();
    m9 = 36'h5_5AA5_A55A;
    doWrite(9, m9, 4'b0000);
    for (int k = 0; k < 3; k++) begin
      setCmd(9, 1'b1, 4'b0000);
      if (k == 0) ce1N = 1'b1;
      if (k == 1) ce2  = 1'b0;
      if (k == 2) ce3N = 1'b1;
      tick();
      setIdle();
      tick();
      dIn = 36'h3_3333_3333;
      tick();
      doRead(9, m9, "R4 write with one enable off ignored");
    end
    setCmd(9, 1'b0, '1);
    ce2 = 1'b0;
    tick();
    setIdle();
    tick();
    tick();
    chkBit("R4 deselected read leaves dOe low", dOe, 1'b0);
  endtask

  task automatic t_burst();
    logic [DW-1:0] bd [4];
    logic [ADDR_W-1:0] seq [4];
    seq[0] = 6; seq[1] = 7; seq[2] = 4; seq[3] = 5;
    for (int i = 0; i < 4; i++) bd[i] = 36'h1_0000_0000 * (i + 2) + 36'(i * 17 + 3);
    for (int i = 0; i < 6; i++) begin
      if (i == 0) setCmd(6, 1'b1, 4'b0000);
      else if (i < 4) begin advLd = 1'b1; addr = 6'd63; end
      else setIdle();
      if (i >= 2) dIn = bd[i-2];
      tick();
    end
    doRead(4, bd[2], "R5 burst wrapped to word 4");
    doRead(7, bd[1], "R5 burst stepped to word 7");
    for (int i = 0; i < 7; i++) begin
      if (i == 0) setCmd(6, 1'b0, '1);
      else if (i < 4) begin advLd = 1'b1; addr = 6'd0; end
      else setIdle();
      tick();
      if (i >= 2 && i < 6) begin
        chk("R5 burst read order", dOut, bd[i-2]);
        chkBit("R5 burst read drives", dOe, 1'b1);
      end
    end
    m5 = bd[3];
  endtask

  task automatic t_stall();
    doRead(9, m9, "R6 before stall");
    setCmd(9, 1'b1, 4'b0000);
    dIn  = 36'hE_EEEE_EEEE;
    cenN = 1'b1;
    repeat (4) tick();
    chk("R6 dOut held while stalled", dOut, m9);
    chkBit("R6 dOe held while stalled", dOe, 1'b1);
    oeN = 1'b1;
    #1;
    chkBit("R7 oeN high drops dOe", dOe, 1'b0);
    oeN = 1'b0;
    #1;
    chkBit("R7 oeN low restores dOe", dOe, 1'b1);
    tick();
    setIdle();
    tick();
    tick();
    tick();
    chkBit("R6 nothing taken while stalled", dOe, 1'b0);
    doRead(9, m9, "R6 stalled write ignored");
  endtask

  task automatic t_wrslot();
    logic [DW-1:0] w = 36'h7_1357_9BDF;
    setCmd(5, 1'b0, '1);
    tick();
    setCmd(12, 1'b1, 4'b0000);
    tick();
    setIdle();
    tick();
    chk("R8 preceding read data", dOut, m5);
    chkBit("R8 preceding read drives", dOe, 1'b1);
    dIn = w;
    tick();
    chkBit("R8 write data slot quiet", dOe, 1'b0);
    doRead(12, w, "R8 write after read stored");
  endtask

  task automatic t_advNoop();
    setIdle();
    tick();
    setCmd(9, 1'b1, 4'b0000);
    advLd = 1'b1;
    tick();
    setIdle();
    tick();
    dIn = 36'h9_9999_9999;
    tick();
    chkBit("R9 advance after deselect quiet", dOe, 1'b0);
    doRead(9, m9, "R9 advance after deselect no write");
  endtask

  task automatic t_b2b();
    logic [DW-1:0] v = 36'h2_468A_CE02;
    setCmd(20, 1'b1, 4'b0000);
    tick();
    setCmd(20, 1'b0, '1);
    tick();
    setIdle();
    dIn = v;
    tick();
    tick();
    chk("R10 read right after write", dOut, v);
    chkBit("R10 read drives", dOe, 1'b1);
  endtask

  initial begin
    rstN = 1'b0; oeN = 1'b0; addr = '0; dIn = '0;
    setIdle();
    repeat (3) tick();
    rstN = 1'b1;
    t_reset();
    t_basic();
    t_bytes();
    t_select();
    t_burst();
    t_stall();
    t_wrslot();
    t_advNoop();
    t_b2b();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule